// File: doc/BRIEF.md
# Half-Duplex Serial Echo Engine

This block receives one 8N1 character on a serial input and sends the same byte back on a serial output as a complete frame. After that it waits for the next character. A single free-running counter sets all of the bit timing. Each sampling or launch instant is a compare point. The next compare point is the previous one plus one bit period, so rounding never builds up across a frame, even when the counter wraps around.

The receive line passes through a two-stage synchronizer. A falling edge on the synchronized line arms reception while the block is idle. The first data sample falls one and a half bit periods after that edge. Each following sample comes one bit period after the one before it. Once the eighth bit is taken, the byte is presented with a single-cycle strobe. The transmitter then uses the same compare channel to send the echo. A frame that arrives during the echo is ignored, so the link is strictly half-duplex. The engine re-arms only after the echo's stop bit has fully ended.

Top module: `uart_echo_engine`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `tx_line` is 1, `busy` is 0 and `rx_valid` is 0.
- R2: A falling edge of `rx_line` while idle starts reception and raises `busy`. With the default 208-clock bit period, `rx_valid` rises exactly 1771 clocks after the input falls. This is 2 clocks of synchronizer, 1 clock of edge detection, 312 clocks to the first sample and 7×208 clocks for the rest.
- R3: The eight samples are assembled least significant bit first. `rx_data` carries the byte during the single cycle in which `rx_valid` is 1.
- R4: The echo's start bit (`tx_line` falling to 0) begins exactly 208 clocks after the cycle in which `rx_valid` is 1.
- R5: The echo frame has ten cells of 208 clocks each. Cell 0 is a 0 start bit, cells 1 to 8 are data bits 0 to 7, and cell 9 is a 1 stop bit. Every transition of `tx_line` falls a whole number of bit periods after the `rx_valid` cycle.
- R6: `busy` falls exactly 2288 clocks (eleven bit periods) after the `rx_valid` cycle, at the end of the stop bit, with `tx_line` at 1.
- R7: Activity on `rx_line` during the echo produces no `rx_valid` and does not re-arm reception. Each busy period yields exactly one `rx_valid`. A new frame sent after `busy` falls is received normally.
- R8: Frame timing and data stay exact across any number of consecutive frames, including frames that straddle a wrap of the internal counter.
- R9: While `busy` is 0, `tx_line` is 1 and does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the bit-timing counter clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_line | input | 1 | Asynchronous serial input, idles high |
| tx_line | output | 1 | Serial output, idles high |
| rx_valid | output | 1 | One-cycle strobe when a byte has been received |
| rx_data | output | 8 | Received byte, valid with `rx_valid` |
| busy | output | 1 | High from the detected start edge until the echo stop bit ends |

## Verification
On every cycle, the checker module enforces the following. The output stays quiet and high while idle. Each strobe is a single cycle, and there is at most one strobe per busy period. Every output transition, and the fall of `busy`, lands on a whole bit period measured from the strobe. The bench is needed for the end-to-end timing from the input edge to the strobe. It also confirms the received byte against the stimulus and the bit-by-bit contents of the echo. It further shows that a second start edge injected during the echo is ignored, and that timing holds across counter wrap-around over many random bytes and gaps.

// File: rtl/uart_echo_pkg.sv
package uart_echo_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RECV = 2'd1,
        ST_SEND = 2'd2
    } echo_state_e;

endpackage

// File: rtl/uart_echo_sync.sv
module uart_echo_sync #(
    parameter int STAGES   = 2,
    parameter bit IDLE_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic level,
    output logic fall
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CHAIN_W-2:0], async_in};
    end

    always_ff @(posedge clk) begin
        if (rst) chain_q <= {CHAIN_W{IDLE_VAL}};
        else     chain_q <= chain_d;
    end

    // stage STAGES-1 is the synchronized level, stage STAGES its previous value
    assign level = chain_q[STAGES-1];
    assign fall  = chain_q[STAGES] & ~chain_q[STAGES-1];

endmodule

// File: rtl/uart_echo_timer.sv
module uart_echo_timer #(
    parameter int CNT_W     = 16,
    parameter int BIT_TICKS = 208
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic [CNT_W-1:0] arm_ofs,
    input  logic             step,
    output logic             hit
);
    localparam logic [CNT_W-1:0] PERIOD = CNT_W'(BIT_TICKS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cmp;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d     = tmr_q;
        tmr_d.cnt = tmr_q.cnt + 1'b1;
        if (arm)       tmr_d.cmp = tmr_q.cnt + arm_ofs;
        else if (step) tmr_d.cmp = tmr_q.cmp + PERIOD;
    end

    always_ff @(posedge clk) begin
        if (rst) tmr_q <= '0;
        else     tmr_q <= tmr_d;
    end

    assign hit = (tmr_q.cnt == tmr_q.cmp);

endmodule

// File: rtl/uart_echo_engine.sv
module uart_echo_engine #(
    parameter int DATA_W     = 8,
    parameter int BIT_TICKS  = 208,
    parameter int HALF_TICKS = 104,
    parameter int CNT_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_line,
    output logic              tx_line,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              busy
);
    import uart_echo_pkg::*;

    localparam int FRAME_BITS = DATA_W + 2;
    localparam int RXC_W      = $clog2(DATA_W + 1);
    localparam int TXC_W      = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] FIRST_OFS  = CNT_W'(BIT_TICKS + HALF_TICKS);
    localparam logic [CNT_W-1:0] LAUNCH_OFS = CNT_W'(BIT_TICKS);

    typedef struct packed {
        echo_state_e           state;
        logic [DATA_W-1:0]     rx_shift;
        logic [RXC_W-1:0]      rx_left;
        logic [FRAME_BITS-1:0] tx_shift;
        logic [TXC_W-1:0]      tx_left;
        logic                  tx;
        logic                  valid;
        logic [DATA_W-1:0]     data;
    } eng_t;

    eng_t eng_d, eng_q;

    logic             rx_s, rx_fall;
    logic             hit, arm, step;
    logic [CNT_W-1:0] arm_ofs;
    logic [DATA_W-1:0] rx_next;

    uart_echo_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (rx_line),
        .level    (rx_s),
        .fall     (rx_fall)
    );

    uart_echo_timer #(.CNT_W(CNT_W), .BIT_TICKS(BIT_TICKS)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .arm     (arm),
        .arm_ofs (arm_ofs),
        .step    (step),
        .hit     (hit)
    );

    assign rx_next = DATA_W'({rx_s, eng_q.rx_shift} >> 1);

    always_comb begin
        eng_d       = eng_q;
        eng_d.valid = 1'b0;
        arm         = 1'b0;
        step        = 1'b0;
        arm_ofs     = LAUNCH_OFS;
        case (eng_q.state)
            ST_IDLE: begin
                if (rx_fall) begin
                    eng_d.state   = ST_RECV;
                    eng_d.rx_left = RXC_W'(DATA_W);
                    arm           = 1'b1;
                    arm_ofs       = FIRST_OFS;
                end
            end
            ST_RECV: begin
                if (hit) begin
                    eng_d.rx_shift = rx_next;
                    if (eng_q.rx_left == RXC_W'(1)) begin
                        eng_d.valid    = 1'b1;
                        eng_d.data     = rx_next;
                        eng_d.tx_shift = {1'b1, rx_next, 1'b0};
                        eng_d.tx_left  = TXC_W'(FRAME_BITS);
                        eng_d.state    = ST_SEND;
                        arm            = 1'b1;
                        arm_ofs        = LAUNCH_OFS;
                    end else begin
                        eng_d.rx_left = eng_q.rx_left - 1'b1;
                        step          = 1'b1;
                    end
                end
            end
            ST_SEND: begin
                if (hit) begin
                    if (eng_q.tx_left == '0) begin
                        eng_d.state = ST_IDLE;
                    end else begin
                        eng_d.tx       = eng_q.tx_shift[0];
                        eng_d.tx_shift = FRAME_BITS'({1'b1, eng_q.tx_shift} >> 1);
                        eng_d.tx_left  = eng_q.tx_left - 1'b1;
                        step           = 1'b1;
                    end
                end
            end
            default: eng_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            eng_q          <= '0;
            eng_q.state    <= ST_IDLE;
            eng_q.tx       <= 1'b1;
            eng_q.tx_shift <= '1;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign tx_line  = eng_q.tx;
    assign rx_valid = eng_q.valid;
    assign rx_data  = eng_q.data;
    assign busy     = (eng_q.state != ST_IDLE);

endmodule

// File: rtl/uart_echo_checker.sv
module uart_echo_checker #(
    parameter int BIT_TICKS  = 208,
    parameter int FRAME_BITS = 10
) (
    input logic clk,
    input logic rst,
    input logic tx_line,
    input logic rx_valid,
    input logic busy
);
    localparam int SINCE_W  = 16;
    localparam int END_TICK = BIT_TICKS * (FRAME_BITS + 1);
    localparam logic [SINCE_W-1:0] SAT = '1;

    logic [SINCE_W-1:0] since_q;
    logic [1:0]         strobes_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q   <= SAT;
            strobes_q <= '0;
        end else begin
            if (rx_valid)          since_q <= SINCE_W'(1);
            else if (since_q != SAT) since_q <= since_q + 1'b1;
            if (!busy)             strobes_q <= '0;
            else if (rx_valid && strobes_q != 2'd3) strobes_q <= strobes_q + 1'b1;
        end
    end

    // R9
    idle_line_high_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> tx_line);

    // R9
    idle_line_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy)) |-> $stable(tx_line));

    // R3
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R7
    strobe_once_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> (busy && strobes_q == 2'd0));

    // R5
    cell_grid_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(tx_line) |-> (since_q != SAT && (32'(since_q) % BIT_TICKS) == 0));

    // R6
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (32'(since_q) == END_TICK && tx_line));

endmodule

bind uart_echo_engine uart_echo_checker #(
    .BIT_TICKS  (BIT_TICKS),
    .FRAME_BITS (DATA_W + 2)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tx_line  (tx_line),
    .rx_valid (rx_valid),
    .busy     (busy)
);

// File: tb/uart_echo_engine_test.sv
`timescale 1ns/1ps
module uart_echo_engine_test;

    localparam int BITP     = 208;
    localparam int T_VALID  = 1771;
    localparam int T_LAUNCH = 208;
    localparam int T_END    = 2288;
    localparam int WINDOW   = 2600;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_line = 1'b1;
    logic       tx_line, rx_valid, busy;
    logic [7:0] rx_data;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    uart_echo_engine uut (
        .clk      (clk),
        .rst      (rst),
        .rx_line  (rx_line),
        .tx_line  (tx_line),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .busy     (busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    function automatic logic [9:0] frame_of(input logic [7:0] b);
        return {1'b1, b, 1'b0};
    endfunction

    task automatic drive_frame(input logic [7:0] b, input bit glitch);
        rx_line = 1'b0;
        repeat (BITP) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_line = b[i];
            repeat (BITP) @(negedge clk);
        end
        rx_line = 1'b1;
        repeat (BITP) @(negedge clk);
        if (glitch) begin
            repeat (600) @(negedge clk);
            rx_line = 1'b0;
            repeat (300) @(negedge clk);
            rx_line = 1'b1;
        end
    endtask

    task automatic watch_frame(input logic [7:0] b);
        int t = 0;
        int fall_at = -1;
        int end_at = -1;
        int extra = 0;
        int rearm = 0;
        int idx = 0;
        logic [9:0] got = '0;
        logic [9:0] exp_f = frame_of(b);
        while (!rx_valid && t < 4000) begin
            @(negedge clk);
            t++;
        end
        // R2: strobe timing from input edge
        check(t == T_VALID, "R2 strobe delay", t, T_VALID);
        // R3: LSB-first byte with strobe
        check(rx_data == b, "R3 received byte", rx_data, b);
        for (int k = 1; k <= WINDOW; k++) begin
            @(negedge clk);
            if (rx_valid) extra++;
            if (!tx_line && fall_at < 0) fall_at = k;
            if (k >= T_LAUNCH + BITP/2 && ((k - T_LAUNCH - BITP/2) % BITP) == 0 && idx < 10) begin
                got[idx] = tx_line;
                idx++;
            end
            if (!busy && end_at < 0) end_at = k;
            if (end_at >= 0 && busy) rearm++;
        end
        // R4
        check(fall_at == T_LAUNCH, "R4 echo start delay", fall_at, T_LAUNCH);
        // R5
        check(got == exp_f, "R5 echo frame", got, exp_f);
        // R6
        check(end_at == T_END, "R6 busy end", end_at, T_END);
        // R7
        check(extra == 0, "R7 no strobe during echo", extra, 0);
        check(rearm == 0, "R7 no re-arm from echo-time activity", rearm, 0);
    endtask

    task automatic run_frame(input logic [7:0] b, input bit glitch);
        @(negedge clk);
        fork
            drive_frame(b, glitch);
            watch_frame(b);
        join
    endtask

    task automatic idle_gap(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        // R9
        check(tx_line == 1'b1 && busy == 1'b0, "R9 idle line high", {busy, tx_line}, 1);
    endtask

    initial begin
        #(190000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual run not finished, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] directed [6];
        directed[0] = 8'h00; directed[1] = 8'hFF; directed[2] = 8'h55;
        directed[3] = 8'hAA; directed[4] = 8'h01; directed[5] = 8'h80;
        void'($urandom(32'd4711));
        repeat (6) @(negedge clk);
        // R1
        check(tx_line == 1'b1 && busy == 1'b0 && rx_valid == 1'b0,
              "R1 reset outputs", {rx_valid, busy, tx_line}, 1);
        rst = 1'b0;
        @(negedge clk);
        check(tx_line == 1'b1 && busy == 1'b0 && rx_valid == 1'b0,
              "R1 after reset", {rx_valid, busy, tx_line}, 1);
        idle_gap(20);
        for (int i = 0; i < 6; i++) begin
            run_frame(directed[i], i == 2);
            idle_gap(5);
        end
        // R8: many frames with random data and gaps, crossing counter wrap
        for (int i = 0; i < 22; i++) begin
            logic [7:0] b = 8'($urandom);
            bit g = ($urandom % 4) == 0;
            run_frame(b, g);
            idle_gap(1 + int'($urandom % 300));
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule